// File: doc/BRIEF.md
# NOR Flash Command Sequencer

This block is a synchronous model of a NOR-style parallel flash device. It sits on a plain bus: a byte address, a write strobe with write data, and a read strobe with registered read data. Inside is a small word array split into equal power-of-two sectors. A command state machine reads the low byte of each write as a command code or as a follow-up. The supported sequences are single-word programming, sector erase with a confirm code, counted multi-word programming, lock and unlock sequences, and status read and clear. A query mode returns bytes from a fixed identification table.

Depending on the pending command, a read returns array words, the 8-bit status byte (zero-extended) or a query-table byte (zero-extended). Bit 7 of the status byte is the ready flag. A sector erase does not finish at once: the sector is overwritten with all-ones one word per clock. Ready stays low until the last word is written. Software polls the status byte the same way it would on a real device.

The array depth, the sector size and the word width are parameters. The word width is 1, 2 or 4 bytes. A bus address is a byte address, and the word index is that address shifted right by log2 of the word width.

Top module: `nor_cmd_flash`

## Requirements
- R1: After reset the array reads all-ones, the status byte is 0x00, and the device is in array-read mode.
- R2: A write of 0x10 or 0x40 in command position arms a program. The next write stores its data at its word address, sets status bit 7 and returns to array-read mode. Only the low 8 data bits are taken as a command code.
- R3: While a program, erase, lock, buffered-write or status command is pending, a read returns the status byte in bits 7:0 with zero upper bits.
- R4: Code 0x20 erases the sector containing the write address, one word per clock. Status bit 7 is low for the whole walk and is set when the last word is written. Words in other sectors keep their values.
- R5: The write that follows 0x20 always returns to array-read mode. Only 0xD0 requests the ready flag; 0xFF and any other code do not.
- R6: While an erase walk runs, program and buffered data writes leave the array unchanged. Confirm codes do not raise the ready flag.
- R7: Code 0x50 clears the whole status byte to 0x00 and returns to array-read mode.
- R8: Code 0x70 makes reads return the status byte. The next write is still decoded as a command code.
- R9: Code 0xE8 sets ready. The next write gives a count N, and the following N+1 writes each store one word. A further 0xD0 returns to array-read mode with ready set; any other value also returns to array-read mode.
- R10: Code 0x60 followed by 0xD0 or 0x01 sets ready. Followed by any other code, it returns to array-read mode with status unchanged.
- R11: Code 0x98 enters query mode. The table index is address bits 7:0 shifted right by log2 of the word width. Index 0x10..0x12 reads 0x51, 0x52, 0x59, index 0x27 reads log2 of the array size in bytes, and index 0x2D reads the sector count minus one. An index of 0x40 or more reads 0. Only 0xFF leaves; other writes are ignored.
- R12: In command position, 0xFF, 0x00 or an unlisted code returns to array-read mode and leaves the status byte unchanged.
- R13: Read data appears on the clock edge that samples the read strobe and holds until the next read. A read in the same cycle as a write sees the mode from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | log2(ARRAY_BYTES) | Byte address of the access |
| bus_wdata | input | 8*DATA_BYTES | Write data; low byte carries command codes |
| bus_we | input | 1 | Write strobe, one write per asserted cycle |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 8*DATA_BYTES | Registered read data |

## Verification
Two functions can land in the same cycle: the erase walker owns the array write port and the ready flag, and a bus write may at the same time try to program a word or complete a confirm. The bench starts a walk, confirms it at once, and then arms and issues a program to a word in another sector. It then reads the status byte mid-walk, expecting ready low, and after the walk reads that word back, expecting it unchanged. A second collision is a read and a command write in one cycle. It is judged by the read returning the mode from before the write.

// File: rtl/nfl_pkg.sv
package nfl_pkg;

    typedef enum logic [3:0] {
        ST_ARRAY,
        ST_STATUS,
        ST_PROG,
        ST_ERASE,
        ST_LOCK,
        ST_QUERY,
        ST_BUF_CNT,
        ST_BUF_DATA,
        ST_BUF_CONF
    } fl_state_e;

    // events that update the status byte in one cycle
    typedef struct packed {
        logic clear_all;
        logic drop_ready;
        logic raise_ready;
    } stat_evt_t;

    localparam logic [7:0] OP_PROG_A   = 8'h10;
    localparam logic [7:0] OP_PROG_B   = 8'h40;
    localparam logic [7:0] OP_ERASE    = 8'h20;
    localparam logic [7:0] OP_CLEAR    = 8'h50;
    localparam logic [7:0] OP_LOCK     = 8'h60;
    localparam logic [7:0] OP_STATUS   = 8'h70;
    localparam logic [7:0] OP_QUERY    = 8'h98;
    localparam logic [7:0] OP_BUFWR    = 8'hE8;
    localparam logic [7:0] OP_READ     = 8'hFF;
    localparam logic [7:0] OP_CONFIRM  = 8'hD0;
    localparam logic [7:0] OP_LOCK_ALT = 8'h01;

    localparam int READY_BIT = 7;
    localparam int QUERY_LEN = 64;
    localparam int BUF_CNT_W = 8;

    // mode entered by a command code written in command position
    function automatic fl_state_e cmd_next_state(input logic [7:0] op);
        case (op)
            OP_PROG_A, OP_PROG_B: return ST_PROG;
            OP_ERASE:             return ST_ERASE;
            OP_LOCK:              return ST_LOCK;
            OP_STATUS:            return ST_STATUS;
            OP_QUERY:             return ST_QUERY;
            OP_BUFWR:             return ST_BUF_CNT;
            default:              return ST_ARRAY;
        endcase
    endfunction

    function automatic logic accepts_command(input fl_state_e s);
        return (s == ST_ARRAY) || (s == ST_STATUS);
    endfunction

endpackage

// File: rtl/nfl_array.sv
module nfl_array #(
    parameter int WORDS  = 128,
    parameter int DATA_W = 16
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     we,
    input  logic [$clog2(WORDS)-1:0] waddr,
    input  logic [DATA_W-1:0]        wdata,
    input  logic [$clog2(WORDS)-1:0] raddr,
    output logic [DATA_W-1:0]        rdata
);
    logic [DATA_W-1:0] mem_q [WORDS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < WORDS; i++) begin
                mem_q[i] <= '1;
            end
        end else if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/nfl_erase_walker.sv
module nfl_erase_walker #(
    parameter int WORDS     = 128,
    parameter int SEC_WORDS = 32
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     start,
    input  logic [$clog2(WORDS)-1:0] base,
    output logic                     busy,
    output logic                     done,
    output logic                     we,
    output logic [$clog2(WORDS)-1:0] addr
);
    localparam int AW = $clog2(WORDS);
    localparam int SW = $clog2(SEC_WORDS);
    localparam logic [AW-1:0] OFS_MASK = AW'(SEC_WORDS - 1);

    logic          busy_q;
    logic [AW-1:0] ptr_q;
    logic          last_word;

    assign last_word = &ptr_q[SW-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            ptr_q  <= '0;
        end else if (busy_q) begin
            if (last_word) begin
                busy_q <= 1'b0;
            end else begin
                ptr_q <= ptr_q + AW'(1);
            end
        end else if (start) begin
            busy_q <= 1'b1;
            ptr_q  <= base & ~OFS_MASK;
        end
    end

    assign busy = busy_q;
    assign done = busy_q && last_word;
    assign we   = busy_q;
    assign addr = ptr_q;
endmodule

// File: rtl/nfl_query_rom.sv
module nfl_query_rom #(
    parameter int ARRAY_BYTES  = 256,
    parameter int SECTOR_BYTES = 64,
    parameter int DATA_BYTES   = 2
) (
    input  logic [7:0] idx,
    output logic [7:0] qdata
);
    import nfl_pkg::*;

    localparam int            NSEC     = ARRAY_BYTES / SECTOR_BYTES;
    localparam logic [15:0]   NSEC_M1  = 16'(NSEC - 1);
    localparam logic [23:0]   SEC_SIZE = 24'(SECTOR_BYTES);
    localparam logic [7:0]    SIZE_LOG = 8'($clog2(ARRAY_BYTES));
    localparam logic [7:0]    BUF_LOG  = (DATA_BYTES == 1) ? 8'h08 : 8'h0B;

    always_comb begin
        qdata = 8'h00;
        if (int'(idx) < QUERY_LEN) begin
            case (idx)
                8'h10: qdata = 8'h51;
                8'h11: qdata = 8'h52;
                8'h12: qdata = 8'h59;
                8'h13: qdata = 8'h01;
                8'h15: qdata = 8'h31;
                8'h1B: qdata = 8'h45;
                8'h1C: qdata = 8'h55;
                8'h1F, 8'h20: qdata = 8'h07;
                8'h21: qdata = 8'h0A;
                8'h23, 8'h24, 8'h25: qdata = 8'h04;
                8'h27: qdata = SIZE_LOG;
                8'h28: qdata = 8'h02;
                8'h2A: qdata = BUF_LOG;
                8'h2C: qdata = 8'h01;
                8'h2D: qdata = NSEC_M1[7:0];
                8'h2E: qdata = NSEC_M1[15:8];
                8'h2F: qdata = SEC_SIZE[15:8];
                8'h30: qdata = SEC_SIZE[23:16];
                8'h31: qdata = 8'h50;
                8'h32: qdata = 8'h52;
                8'h33: qdata = 8'h49;
                8'h34, 8'h35: qdata = 8'h31;
                default: qdata = 8'h00;
            endcase
        end
    end
endmodule

// File: rtl/nfl_cmd_fsm.sv
module nfl_cmd_fsm
    import nfl_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 bus_we,
    input  logic [7:0]           op,
    input  logic                 erase_busy,
    input  logic                 erase_done,
    output fl_state_e            state,
    output logic [7:0]           status,
    output logic [BUF_CNT_W-1:0] buf_cnt,
    output logic                 arr_we,
    output logic                 erase_start
);
    fl_state_e            st_q, st_d;
    logic [7:0]           stat_q, stat_d;
    logic [BUF_CNT_W-1:0] cnt_q, cnt_d;
    stat_evt_t            evt;

    always_comb begin
        st_d        = st_q;
        cnt_d       = cnt_q;
        evt         = '0;
        arr_we      = 1'b0;
        erase_start = 1'b0;
        if (bus_we) begin
            case (st_q)
                ST_ARRAY, ST_STATUS: begin
                    st_d = cmd_next_state(op);
                    if (op == OP_ERASE) begin
                        erase_start    = 1'b1;
                        evt.drop_ready = 1'b1;
                    end
                    if (op == OP_CLEAR)  evt.clear_all   = 1'b1;
                    if (op == OP_BUFWR)  evt.raise_ready = 1'b1;
                end
                ST_PROG: begin
                    arr_we          = !erase_busy;
                    evt.raise_ready = 1'b1;
                    st_d            = ST_ARRAY;
                end
                ST_ERASE: begin
                    evt.raise_ready = (op == OP_CONFIRM);
                    st_d            = ST_ARRAY;
                end
                ST_LOCK: begin
                    evt.raise_ready = (op == OP_CONFIRM) || (op == OP_LOCK_ALT);
                    st_d            = ST_ARRAY;
                end
                ST_QUERY: begin
                    if (op == OP_READ) st_d = ST_ARRAY;
                end
                ST_BUF_CNT: begin
                    cnt_d = op[BUF_CNT_W-1:0];
                    st_d  = ST_BUF_DATA;
                end
                ST_BUF_DATA: begin
                    arr_we          = !erase_busy;
                    evt.raise_ready = 1'b1;
                    if (cnt_q == '0) begin
                        st_d = ST_BUF_CONF;
                    end else begin
                        cnt_d = cnt_q - BUF_CNT_W'(1);
                    end
                end
                ST_BUF_CONF: begin
                    evt.raise_ready = (op == OP_CONFIRM);
                    st_d            = ST_ARRAY;
                end
                default: st_d = ST_ARRAY;
            endcase
        end
    end

    // a running walk owns the ready flag; its end is applied last
    always_comb begin
        stat_d = stat_q;
        if (evt.clear_all) stat_d = '0;
        if (evt.drop_ready && !erase_busy) stat_d[READY_BIT] = 1'b0;
        if (evt.raise_ready && !erase_busy) stat_d[READY_BIT] = 1'b1;
        if (erase_done) stat_d[READY_BIT] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_ARRAY;
            stat_q <= '0;
            cnt_q  <= '0;
        end else begin
            st_q   <= st_d;
            stat_q <= stat_d;
            cnt_q  <= cnt_d;
        end
    end

    assign state   = st_q;
    assign status  = stat_q;
    assign buf_cnt = cnt_q;
endmodule

// File: rtl/nor_cmd_flash.sv
module nor_cmd_flash
    import nfl_pkg::*;
#(
    parameter int DATA_BYTES   = 2,
    parameter int ARRAY_BYTES  = 256,
    parameter int SECTOR_BYTES = 64
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic [$clog2(ARRAY_BYTES)-1:0] bus_addr,
    input  logic [8*DATA_BYTES-1:0]        bus_wdata,
    input  logic                           bus_we,
    input  logic                           bus_re,
    output logic [8*DATA_BYTES-1:0]        bus_rdata
);
    localparam int DATA_W    = 8 * DATA_BYTES;
    localparam int ADDR_W    = $clog2(ARRAY_BYTES);
    localparam int BSH       = $clog2(DATA_BYTES);
    localparam int WORDS     = ARRAY_BYTES / DATA_BYTES;
    localparam int SEC_WORDS = SECTOR_BYTES / DATA_BYTES;
    localparam int WAW       = ADDR_W - BSH;

    fl_state_e            fsm_state;
    logic [7:0]           status_q;
    logic [BUF_CNT_W-1:0] buf_cnt;
    logic                 fsm_arr_we;
    logic                 erase_start;
    logic                 erase_busy;
    logic                 erase_done;
    logic                 erase_we;
    logic [WAW-1:0]       erase_addr;
    logic [WAW-1:0]       word_idx;
    logic                 arr_we;
    logic [WAW-1:0]       arr_waddr;
    logic [DATA_W-1:0]    arr_wdata;
    logic [DATA_W-1:0]    arr_rdata;
    logic [7:0]           qbyte_addr;
    logic [7:0]           qidx;
    logic [7:0]           qdata;
    logic [DATA_W-1:0]    rd_mux;
    logic [DATA_W-1:0]    rdata_q;

    assign word_idx = bus_addr[ADDR_W-1:BSH];

    generate
        if (ADDR_W >= 8) begin : g_qaddr_wide
            assign qbyte_addr = bus_addr[7:0];
        end else begin : g_qaddr_narrow
            assign qbyte_addr = {{(8 - ADDR_W){1'b0}}, bus_addr};
        end
    endgenerate

    assign qidx = qbyte_addr >> BSH;

    nfl_cmd_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .bus_we     (bus_we),
        .op         (bus_wdata[7:0]),
        .erase_busy (erase_busy),
        .erase_done (erase_done),
        .state      (fsm_state),
        .status     (status_q),
        .buf_cnt    (buf_cnt),
        .arr_we     (fsm_arr_we),
        .erase_start(erase_start)
    );

    nfl_erase_walker #(
        .WORDS    (WORDS),
        .SEC_WORDS(SEC_WORDS)
    ) u_walker (
        .clk  (clk),
        .rst  (rst),
        .start(erase_start),
        .base (word_idx),
        .busy (erase_busy),
        .done (erase_done),
        .we   (erase_we),
        .addr (erase_addr)
    );

    // the walker owns the write port while it runs
    assign arr_we    = erase_we || fsm_arr_we;
    assign arr_waddr = erase_we ? erase_addr : word_idx;
    assign arr_wdata = erase_we ? '1 : bus_wdata;

    nfl_array #(
        .WORDS (WORDS),
        .DATA_W(DATA_W)
    ) u_array (
        .clk  (clk),
        .rst  (rst),
        .we   (arr_we),
        .waddr(arr_waddr),
        .wdata(arr_wdata),
        .raddr(word_idx),
        .rdata(arr_rdata)
    );

    nfl_query_rom #(
        .ARRAY_BYTES (ARRAY_BYTES),
        .SECTOR_BYTES(SECTOR_BYTES),
        .DATA_BYTES  (DATA_BYTES)
    ) u_query (
        .idx  (qidx),
        .qdata(qdata)
    );

    always_comb begin
        case (fsm_state)
            ST_ARRAY: rd_mux = arr_rdata;
            ST_QUERY: rd_mux = DATA_W'(qdata);
            default:  rd_mux = DATA_W'(status_q);
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q <= '0;
        end else if (bus_re) begin
            rdata_q <= rd_mux;
        end
    end

    assign bus_rdata = rdata_q;
endmodule

// File: rtl/nfl_checker.sv
module nfl_checker
    import nfl_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 bus_we,
    input logic                 bus_re,
    input logic [7:0]           op,
    input logic [DATA_W-1:0]    bus_rdata,
    input fl_state_e            state,
    input logic [7:0]           status,
    input logic                 erase_busy,
    input logic                 erase_done,
    input logic [BUF_CNT_W-1:0] buf_cnt
);
    // R4
    erase_ready_low_chk: assert property (@(posedge clk) disable iff (rst)
        erase_busy |-> !status[READY_BIT]);

    // R4
    erase_done_ready_chk: assert property (@(posedge clk) disable iff (rst)
        erase_done |=> status[READY_BIT]);

    // R4
    erase_walk_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (erase_busy && !erase_done) |=> erase_busy);

    // R2
    prog_return_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_we && state == ST_PROG) |=> (state == ST_ARRAY));

    // R9
    buf_last_word_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_we && state == ST_BUF_DATA && buf_cnt == '0) |=> (state == ST_BUF_CONF));

    // R12
    read_cmd_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_we && (state == ST_ARRAY || state == ST_STATUS) && op == 8'hFF)
        |=> (state == ST_ARRAY));

    // R7
    clear_status_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_we && (state == ST_ARRAY || state == ST_STATUS) && op == 8'h50 && !erase_busy)
        |=> (status == 8'h00));

    // R13
    rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !bus_re |=> $stable(bus_rdata));
endmodule

bind nor_cmd_flash nfl_checker #(.DATA_W(DATA_W)) i_nfl_checker (
    .clk       (clk),
    .rst       (rst),
    .bus_we    (bus_we),
    .bus_re    (bus_re),
    .op        (bus_wdata[7:0]),
    .bus_rdata (bus_rdata),
    .state     (fsm_state),
    .status    (status_q),
    .erase_busy(erase_busy),
    .erase_done(erase_done),
    .buf_cnt   (buf_cnt)
);

// File: tb/test_nor_cmd_flash.sv
`timescale 1ns/1ps
module test_nor_cmd_flash;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic        bus_we = 1'b0;
    logic        bus_re = 1'b0;
    logic [15:0] bus_rdata;

    int n_chk  = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    nor_cmd_flash i_nor_cmd_flash (
        .clk      (clk),
        .rst      (rst),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .bus_we   (bus_we),
        .bus_re   (bus_re),
        .bus_rdata(bus_rdata)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [15:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_we    = 1'b1;
        @(negedge clk);
        bus_we    = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [15:0] d);
        bus_addr = a;
        bus_re   = 1'b1;
        @(negedge clk);
        bus_re   = 1'b0;
        d        = bus_rdata;
    endtask

    task automatic rd_chk(input string req, input logic [7:0] a, input logic [15:0] exp);
        logic [15:0] v;
        rd(a, v);
        check(req, v, exp);
    endtask

    // polls the status byte until ready, returns the number of reads
    task automatic wait_ready(output int reads);
        logic [15:0] v;
        reads = 0;
        for (int i = 0; i < 40; i++) begin
            rd(8'h00, v);
            reads++;
            if (v[7]) break;
        end
    endtask

    task automatic t_reset;
        rd_chk("R1 array erased", 8'h00, 16'hFFFF);
        rd_chk("R1 array erased top", 8'hFE, 16'hFFFF);
        wr(8'h00, 16'h0070);
        rd_chk("R1 status zero", 8'h00, 16'h0000);
        wr(8'h00, 16'h00FF);
    endtask

    task automatic t_program;
        wr(8'h06, 16'h0040);
        rd_chk("R3 status while program armed", 8'h06, 16'h0000);
        wr(8'h06, 16'h1234);
        rd_chk("R2 programmed word", 8'h06, 16'h1234);
        wr(8'h00, 16'h0070);
        rd_chk("R2 ready after program", 8'h00, 16'h0080);
        wr(8'h00, 16'h9910);
        wr(8'h46, 16'hBEEF);
        rd_chk("R2 program via 0x10 low byte", 8'h46, 16'hBEEF);
        wr(8'h00, 16'h0040); wr(8'h0A, 16'h5555);
        wr(8'h00, 16'h0040); wr(8'h3E, 16'h2222);
        wr(8'h00, 16'h0040); wr(8'h40, 16'h1111);
    endtask

    task automatic t_erase;
        logic [15:0] v;
        int n;
        wr(8'h0C, 16'h0020);
        rd(8'h00, v);
        check("R4 ready low at walk start", v, 16'h0000);
        wait_ready(n);
        check("R4 walk finishes in sector length", 16'(n <= 33 && n >= 30), 16'h0001);
        wr(8'h00, 16'h00D0);
        rd_chk("R5 confirm returns to array", 8'h06, 16'hFFFF);
        rd_chk("R4 sector erased", 8'h0A, 16'hFFFF);
        rd_chk("R4 last word erased", 8'h3E, 16'hFFFF);
        rd_chk("R4 next sector kept", 8'h40, 16'h1111);
        rd_chk("R4 other word kept", 8'h46, 16'hBEEF);
        wr(8'hC0, 16'h0020);
        wr(8'hC0, 16'h0033);
        rd_chk("R5 bad follow-up returns to array", 8'h46, 16'hBEEF);
        repeat (40) @(negedge clk);
        wr(8'hC0, 16'h0020);
        wr(8'hC0, 16'h00FF);
        rd_chk("R5 0xFF follow-up returns to array", 8'h40, 16'h1111);
        repeat (40) @(negedge clk);
    endtask

    task automatic t_collide;
        int n;
        wr(8'h80, 16'h0020);
        wr(8'h80, 16'h00D0);
        wr(8'h48, 16'h0040);
        wr(8'h48, 16'h7777);
        wr(8'h00, 16'h0070);
        rd_chk("R6 ready held low during walk", 8'h00, 16'h0000);
        wait_ready(n);
        rd_chk("R6 ready after walk", 8'h00, 16'h0080);
        wr(8'h00, 16'h00FF);
        rd_chk("R6 program during walk dropped", 8'h48, 16'hFFFF);
        wr(8'h48, 16'h0040);
        wr(8'h48, 16'h7777);
        rd_chk("R6 program after walk lands", 8'h48, 16'h7777);
    endtask

    task automatic t_buffer;
        wr(8'h00, 16'h0050);
        wr(8'hC0, 16'h00E8);
        rd_chk("R9 ready after buffer command", 8'hC0, 16'h0080);
        wr(8'hC0, 16'h0002);
        rd_chk("R3 status during buffer", 8'hC0, 16'h0080);
        wr(8'hC0, 16'hA001);
        wr(8'hC2, 16'hA002);
        wr(8'hC4, 16'hA003);
        rd_chk("R9 status in confirm step", 8'hC0, 16'h0080);
        wr(8'hC0, 16'h00D0);
        rd_chk("R9 word 0", 8'hC0, 16'hA001);
        rd_chk("R9 word 1", 8'hC2, 16'hA002);
        rd_chk("R9 word 2", 8'hC4, 16'hA003);
        rd_chk("R9 no extra word", 8'hC6, 16'hFFFF);
        wr(8'h00, 16'h0050);
        wr(8'hC8, 16'h00E8);
        wr(8'hC8, 16'h0000);
        wr(8'hC8, 16'hB00B);
        wr(8'hC8, 16'h0012);
        rd_chk("R9 bad confirm returns to array", 8'hC8, 16'hB00B);
    endtask

    task automatic t_lock;
        wr(8'h00, 16'h0050);
        wr(8'h00, 16'h0060); wr(8'h00, 16'h0001);
        wr(8'h00, 16'h0070);
        rd_chk("R10 unlock code sets ready", 8'h00, 16'h0080);
        wr(8'h00, 16'h0050);
        rd_chk("R7 clear returns to array", 8'hC0, 16'hA001);
        wr(8'h00, 16'h0070);
        rd_chk("R7 status cleared", 8'h00, 16'h0000);
        wr(8'h00, 16'h0060); wr(8'h00, 16'h00D0);
        wr(8'h00, 16'h0070);
        rd_chk("R10 lock confirm sets ready", 8'h00, 16'h0080);
        wr(8'h00, 16'h0050);
        wr(8'h00, 16'h0060);
        rd_chk("R3 status during lock", 8'h00, 16'h0000);
        wr(8'h00, 16'h0077);
        rd_chk("R10 unknown code returns to array", 8'hC0, 16'hA001);
        wr(8'h00, 16'h0070);
        rd_chk("R10 unknown code leaves ready low", 8'h00, 16'h0000);
    endtask

    task automatic t_query;
        wr(8'h00, 16'h0098);
        rd_chk("R11 query Q", 8'h20, 16'h0051);
        rd_chk("R11 query R", 8'h22, 16'h0052);
        rd_chk("R11 query Y", 8'h24, 16'h0059);
        rd_chk("R11 size log2", 8'h4E, 16'h0008);
        rd_chk("R11 sector count", 8'h5A, 16'h0003);
        rd_chk("R11 beyond table", 8'h80, 16'h0000);
        wr(8'h00, 16'h0012);
        rd_chk("R11 other write stays in query", 8'h20, 16'h0051);
        wr(8'h00, 16'h00FF);
        rd_chk("R11 0xFF leaves query", 8'hC0, 16'hA001);
    endtask

    task automatic t_status_mode;
        wr(8'h00, 16'h0050);
        wr(8'h00, 16'h0070);
        rd_chk("R8 status mode read", 8'hCA, 16'h0000);
        wr(8'hCA, 16'hAB40);
        wr(8'hCA, 16'h4242);
        rd_chk("R8 command decoded in status mode", 8'hCA, 16'h4242);
        wr(8'h00, 16'h005A);
        rd_chk("R12 unknown code gives array", 8'hCA, 16'h4242);
        wr(8'h00, 16'h0070);
        wr(8'h00, 16'h0000);
        rd_chk("R12 zero code gives array", 8'hCA, 16'h4242);
        wr(8'h00, 16'h0070);
        rd_chk("R12 status unchanged", 8'h00, 16'h0080);
        wr(8'h00, 16'h00FF);
    endtask

    task automatic t_same_cycle;
        logic [15:0] v;
        bus_addr  = 8'hCA;
        bus_wdata = 16'h0070;
        bus_we    = 1'b1;
        bus_re    = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
        bus_re = 1'b0;
        v = bus_rdata;
        check("R13 read sees mode before write", v, 16'h4242);
        repeat (3) @(negedge clk);
        check("R13 data held without read", bus_rdata, 16'h4242);
        rd_chk("R13 next read sees new mode", 8'hCA, 16'h0080);
        wr(8'h00, 16'h00FF);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_program();
        t_erase();
        t_collide();
        t_buffer();
        t_lock();
        t_query();
        t_status_mode();
        t_same_cycle();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule